// File: doc/BRIEF.md
# Bussed Peripheral Command Decoder

This block is the peripheral end of a programmed I/O bus for one device. The processor broadcasts a 6-bit select code together with three timed phase pulses (IOP1, IOP2, IOP4) to every device. The device compares the code with its own fixed address. On a match it turns the phase pulses into its own command pulses IOT1, IOT2 and IOT4. A ready flag inside the block answers flag tests on the skip bus. The same flag holds an interrupt request. Each command pulse has a fixed job.

IOT1 tests the flag. IOT2 does three things at once: it clears the flag, places the device's input word onto the accumulator input bus as an OR contribution, and jam-loads the output register from the accumulator lines. IOT4 starts the device. The device's own work is represented only by a "done" input, which sets the flag. The skip, interrupt and accumulator-input outputs are active-high contributions. Outside the block they are combined by OR with the same outputs of other devices.

All bus lines are treated as synchronous levels sampled on the block clock. A phase pulse that stays high for several cycles simply repeats its action.

Top module: `pio_dev_select`

## Requirements
- R1: `sel_hit` is high exactly when `sel_code` equals parameter `DEV_CODE` (default octal 34).
- R2: `cmd` equals `{iop4, iop2, iop1}` while `sel_hit` is high and is zero otherwise. Bit 0 is IOT1, bit 1 is IOT2 and bit 2 is IOT4.
- R3: `skip_req` is high exactly when IOT1 (`cmd[0]`) is high and the ready flag is set.
- R4: `irq_req` shows the ready flag whether or not the device is selected.
- R5: A high `dev_done` sets the flag, and the flag is visible on the next clock. If IOT2 arrives in the same cycle, `dev_done` wins.
- R6: IOT2 with `dev_done` low clears the flag by the next clock.
- R7: During IOT2, `acc_in_bus[IN_W-1:0]` carries `in_word` and the upper bits are zero. At all other times the bus is all zero, so only 1 bits are ever driven.
- R8: At a clock edge with IOT2 high, `out_reg` loads `acc_out[OUT_W-1:0]`. Otherwise it holds its value, including while `acc_out` changes and the device is not selected.
- R9: When `CLEAR_AC_ON_IN` is 1, `acc_clr_req` is high exactly during IOT2. When it is 0, `acc_clr_req` stays low.
- R10: `dev_start` is high exactly during IOT4.
- R11: After reset the flag is clear (`irq_req` low) and `out_reg` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_code | input | 6 | Broadcast device select code |
| iop | input | 3 | Processor phase pulses: bit 0 IOP1, bit 1 IOP2, bit 2 IOP4 |
| acc_out | input | 12 | Accumulator output lines from the processor |
| in_word | input | IN_W | Device input word offered to the processor |
| dev_done | input | 1 | Device finished; sets the ready flag |
| sel_hit | output | 1 | Select-code match, for subdevice gating |
| cmd | output | 3 | Local command pulses: bit 0 IOT1, bit 1 IOT2, bit 2 IOT4 |
| skip_req | output | 1 | Skip bus contribution |
| irq_req | output | 1 | Interrupt request contribution |
| acc_in_bus | output | 12 | OR contribution to the accumulator input bus |
| acc_clr_req | output | 1 | Accumulator clear request during the input transfer |
| out_reg | output | OUT_W | Output data register |
| dev_start | output | 1 | Start command to the device |

## Verification
The assertions assume that every input is a known, synchronous level once reset has been released. They also assume that `dev_done` and the phase pulses may arrive in any combination, including together in one cycle. The bench changes every input only on the falling clock edge, so these assumptions hold. It sweeps all 64 select codes against all eight phase-pulse patterns, with `dev_done` and the data words varied arithmetically. Every collision of set and clear, and every load while selected or unselected, therefore occurs during the sweep.

// File: rtl/pio_dev_pkg.sv
package pio_dev_pkg;
  localparam int unsigned CODE_W  = 6;
  localparam int unsigned NUM_CMD = 3;
  localparam int unsigned AC_W    = 12;

  typedef logic [NUM_CMD-1:0] cmd_vec_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [AC_W-1:0]    acc_word_t;

  // index of each command pulse inside a cmd_vec_t
  localparam int unsigned SLOT_IOT1 = 0;
  localparam int unsigned SLOT_IOT2 = 1;
  localparam int unsigned SLOT_IOT4 = 2;
endpackage

// File: rtl/pio_code_match.sv
module pio_code_match
  import pio_dev_pkg::*;
#(
  parameter code_t DEV_CODE = 6'o34
) (
  input  code_t    sel_code,
  input  cmd_vec_t iop,
  output logic     hit,
  output cmd_vec_t cmd
);
  assign hit = (sel_code == DEV_CODE);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_pulse
    assign cmd[g] = hit & iop[g];
  end
endmodule

// File: rtl/pio_ready_flag.sv
module pio_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (load_i)  q_o <= d_i;
  end
endmodule

// File: rtl/pio_dev_select.sv
module pio_dev_select
  import pio_dev_pkg::*;
#(
  parameter logic [5:0]  DEV_CODE       = 6'o34,
  parameter int unsigned IN_W           = 12,
  parameter int unsigned OUT_W          = 12,
  parameter int unsigned SKIP_CMD       = SLOT_IOT1,
  parameter int unsigned XFER_CMD       = SLOT_IOT2,
  parameter int unsigned START_CMD      = SLOT_IOT4,
  parameter bit          CLEAR_AC_ON_IN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       sel_code,
  input  logic [2:0]       iop,
  input  logic [11:0]      acc_out,
  input  logic [IN_W-1:0]  in_word,
  input  logic             dev_done,
  output logic             sel_hit,
  output logic [2:0]       cmd,
  output logic             skip_req,
  output logic             irq_req,
  output logic [11:0]      acc_in_bus,
  output logic             acc_clr_req,
  output logic [OUT_W-1:0] out_reg,
  output logic             dev_start
);
  logic ready;
  logic xfer;

  pio_code_match #(.DEV_CODE(DEV_CODE)) u_match (
    .sel_code (sel_code),
    .iop      (iop),
    .hit      (sel_hit),
    .cmd      (cmd)
  );

  assign xfer = cmd[XFER_CMD];

  pio_ready_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (dev_done),
    .clr_i  (xfer),
    .flag_o (ready)
  );

  pio_out_latch #(.W(OUT_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (xfer),
    .d_i    (acc_out[OUT_W-1:0]),
    .q_o    (out_reg)
  );

  assign skip_req  = cmd[SKIP_CMD] & ready;
  assign irq_req   = ready;
  assign dev_start = cmd[START_CMD];

  // OR-style bus contribution: only set bits of the input word are driven
  for (genvar b = 0; b < AC_W; b++) begin : g_acc_in
    if (b < IN_W) begin : g_data
      assign acc_in_bus[b] = xfer & in_word[b];
    end else begin : g_pad
      assign acc_in_bus[b] = 1'b0;
    end
  end

  if (CLEAR_AC_ON_IN) begin : g_clr
    assign acc_clr_req = xfer;
  end else begin : g_noclr
    assign acc_clr_req = 1'b0;
  end
endmodule

// File: rtl/pio_dev_select_chk.sv
module pio_dev_select_chk #(
  parameter logic [5:0]  DEV_CODE       = 6'o34,
  parameter int unsigned OUT_W          = 12,
  parameter int unsigned SKIP_CMD       = 0,
  parameter int unsigned XFER_CMD       = 1,
  parameter int unsigned START_CMD      = 2,
  parameter bit          CLEAR_AC_ON_IN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       sel_code,
  input logic [2:0]       iop,
  input logic [11:0]      acc_out,
  input logic             dev_done,
  input logic             sel_hit,
  input logic [2:0]       cmd,
  input logic             skip_req,
  input logic             irq_req,
  input logic [11:0]      acc_in_bus,
  input logic             acc_clr_req,
  input logic [OUT_W-1:0] out_reg,
  input logic             dev_start
);
  assert_hit_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (sel_code == DEV_CODE));

  assert_quiet_unsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |-> (cmd == 3'b000));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (cmd == iop));

  assert_skip_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (cmd[SKIP_CMD] && irq_req));

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done |=> irq_req);

  assert_xfer_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[XFER_CMD] && !dev_done) |=> !irq_req);

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd[XFER_CMD] && !dev_done) |=> $stable(irq_req));

  assert_in_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_in_bus != 12'd0) |-> cmd[XFER_CMD]);

  assert_out_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[XFER_CMD] |=> (out_reg == $past(acc_out[OUT_W-1:0])));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd[XFER_CMD] |=> $stable(out_reg));

  assert_ac_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_req |-> (CLEAR_AC_ON_IN && cmd[XFER_CMD]));

  assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_start == cmd[START_CMD]);
endmodule

bind pio_dev_select pio_dev_select_chk #(
  .DEV_CODE(DEV_CODE), .OUT_W(OUT_W), .SKIP_CMD(SKIP_CMD),
  .XFER_CMD(XFER_CMD), .START_CMD(START_CMD), .CLEAR_AC_ON_IN(CLEAR_AC_ON_IN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .iop(iop), .acc_out(acc_out),
  .dev_done(dev_done), .sel_hit(sel_hit), .cmd(cmd), .skip_req(skip_req),
  .irq_req(irq_req), .acc_in_bus(acc_in_bus), .acc_clr_req(acc_clr_req),
  .out_reg(out_reg), .dev_start(dev_start)
);

// File: tb/test_pio_dev_select.sv
module test_pio_dev_select;
  localparam int unsigned IN_W  = 8;
  localparam int unsigned OUT_W = 6;
  localparam logic [5:0]  CODE  = 6'o34;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [5:0]       sel_code = '0;
  logic [2:0]       iop = '0;
  logic [11:0]      acc_out = '0;
  logic [IN_W-1:0]  in_word = '0;
  logic             dev_done = 1'b0;
  logic             sel_hit, skip_req, irq_req, acc_clr_req, dev_start;
  logic [2:0]       cmd;
  logic [11:0]      acc_in_bus;
  logic [OUT_W-1:0] out_reg;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  logic             m_flag = 1'b0;
  logic [OUT_W-1:0] m_out = '0;

  always #2 clk = ~clk;

  pio_dev_select #(.DEV_CODE(CODE), .IN_W(IN_W), .OUT_W(OUT_W)) i_pio_dev_select (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .iop(iop), .acc_out(acc_out),
    .in_word(in_word), .dev_done(dev_done), .sel_hit(sel_hit), .cmd(cmd),
    .skip_req(skip_req), .irq_req(irq_req), .acc_in_bus(acc_in_bus),
    .acc_clr_req(acc_clr_req), .out_reg(out_reg), .dev_start(dev_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] code, input logic [2:0] p,
                      input logic done, input logic [11:0] acc, input logic [IN_W-1:0] din);
    logic       hit;
    logic [2:0] ecmd;
    @(negedge clk);
    sel_code = code; iop = p; dev_done = done; acc_out = acc; in_word = din;
    #1;
    hit  = (code == CODE);
    ecmd = hit ? p : 3'b000;
    chk("R1 sel_hit", {31'd0, sel_hit}, {31'd0, hit});
    chk("R2 cmd", {29'd0, cmd}, {29'd0, ecmd});
    chk("R3 skip_req", {31'd0, skip_req}, {31'd0, ecmd[0] & m_flag});
    chk("R4 irq_req", {31'd0, irq_req}, {31'd0, m_flag});
    chk("R7 acc_in_bus", {20'd0, acc_in_bus}, ecmd[1] ? {24'd0, din} : 32'd0);
    chk("R9 acc_clr_req", {31'd0, acc_clr_req}, {31'd0, ecmd[1]});
    chk("R10 dev_start", {31'd0, dev_start}, {31'd0, ecmd[2]});
    chk("R8 out_reg", {26'd0, out_reg}, {26'd0, m_out});
    // model update for the coming edge (R5 set wins, R6 clear, R8 load)
    if (done)         m_flag = 1'b1;
    else if (ecmd[1]) m_flag = 1'b0;
    if (ecmd[1]) m_out = acc[OUT_W-1:0];
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset irq", {31'd0, irq_req}, 32'd0);
    chk("R11 reset out_reg", {26'd0, out_reg}, 32'd0);

    // R5/R6 corner: set while unselected, collide set with clear, then clear
    step(6'o12, 3'b111, 1'b1, 12'h0AB, 8'h5A);
    step(CODE,  3'b001, 1'b0, 12'hFFF, 8'h00);
    step(CODE,  3'b010, 1'b1, 12'h015, 8'hC3);
    step(CODE,  3'b010, 1'b0, 12'h02A, 8'h3C);
    step(CODE,  3'b001, 1'b0, 12'h000, 8'hFF);
    // R8: unselected traffic must not move out_reg
    step(6'o35, 3'b010, 1'b0, 12'hFFF, 8'hFF);
    step(6'o34 ^ 6'o40, 3'b111, 1'b0, 12'h123, 8'h11);

    // sweep every code against every phase-pulse pattern
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 8; p++) begin
        step(6'(c), 3'(p), ((c + p) % 3) == 0,
             12'((c * 97 + p * 13) & 12'hFFF), IN_W'((c * 5 + p * 31) & 8'hFF));
      end
    end
    step(6'o00, 3'b000, 1'b0, 12'h000, 8'h00);

    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule